// File: doc/BRIEF.md
# Doorbell interrupt register block

This block is the register face of a node that shares memory with a group of peers. Software on the node uses a 256-byte window of 32-bit registers to program an interrupt mask, to inspect and acknowledge an interrupt status word, to learn its own node number, and to ring a doorbell on another node. A doorbell write names a destination peer and a vector. The block checks both against a table that holds, for each peer, how many vectors that peer has registered. A doorbell that passes the check leaves the block as a one-cycle notify strobe carrying the peer and vector. A doorbell that fails is dropped without any trace.

Events that target this node's own vectors arrive on a per-vector input. In line mode, any such event overwrites the status word with the value 1. The level interrupt is then driven from the masked status. In message mode, the status word is left alone. Instead, the event becomes a one-cycle request on that vector's message output, but only while message interrupts are enabled. The line output stays low in message mode and whenever the interrupt pin is configured as absent.

A side port fills the per-peer vector-count table. The register port takes a single-cycle access strobe. Read data appears on the cycle after the strobe and holds until the next read.

Top module: `dbell_regs_top`

## Requirements
- R1: After synchronous reset, the mask, status and every peer's vector count are zero. The read data, line interrupt, message requests and notify strobe are also low.
- R2: Word index 0 (byte offset 0) holds the mask. A write loads all 32 bits, and a read at offset 0 returns them. Writes select the register by address bits [7:2] only, so address bits [1:0] have no effect on a write.
- R3: Word index 1 (byte offset 4) holds the status and can be written. With message mode off and the pin present, the line interrupt is high exactly when (status AND mask) is nonzero, one cycle after the write that changed either register.
- R4: A read at offset 4 returns the status value and clears the status to zero in the same access. The line interrupt is low on the following cycle.
- R5: A write at offset 12 is a doorbell. The destination peer is taken from data bits [31:16] and the vector from bits [7:0]; bits [15:8] are ignored. When the check passes, the block raises the notify strobe for exactly one cycle, on the cycle after the write, with that peer and vector.
- R6: A doorbell is dropped, and no strobe appears, if the peer number is not below the table size or the vector is not below that peer's registered count.
- R7: In line mode, an event on any own vector sets the status to exactly 1, replacing the previous value. An event has priority over a status write or read-clear in the same cycle.
- R8: In message mode, an event on vector v raises message request bit v for one cycle, on the next cycle, only if message interrupts are enabled. The status word is not changed.
- R9: The line interrupt is held low while message mode is selected or the pin is configured absent, whatever the status and mask hold.
- R10: A read at offset 8 returns the node ID. Reads at any other offset, and reads with address bits [1:0] nonzero, return zero. Writes to offset 8 or to unmapped offsets change no register and raise no strobe.
- R11: A pulse on the table write port stores an 8-bit count for the indexed peer. That count governs later doorbell checks to that peer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_valid | input | 1 | Single-cycle register access strobe |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 8 | Byte address in the window |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after a read |
| own_id | input | 16 | This node's number |
| msi_mode | input | 1 | 1 selects message interrupts instead of the line |
| pin_present | input | 1 | 0 configures the interrupt pin as absent |
| msix_enable | input | 1 | Message interrupts enabled |
| event_in | input | NUM_VEC | Per-vector incoming event pulses |
| irq_level | output | 1 | Level interrupt line |
| msg_req | output | NUM_VEC | Per-vector message request pulses |
| ring_valid | output | 1 | Doorbell notify strobe |
| ring_peer | output | 16 | Destination peer of the notify |
| ring_vec | output | 8 | Destination vector of the notify |
| tbl_we | input | 1 | Peer table write strobe |
| tbl_idx | input | IDX_W | Peer table index |
| tbl_cnt | input | 8 | Registered vector count to store |

## Verification
Some rules are checked by assertions on every cycle:
- a status read-clear leaves zero behind,
- a line-mode event leaves exactly 1,
- a mask write lands whole,
- a failed doorbell check never produces a strobe,
- a strobe never carries a peer outside the table,
- message requests appear only when message mode and enable were both set.

Other behaviours show only in the bench's scenarios. These are the read data of each offset, the drop on an out-of-range vector after a specific table load, the interaction of the pin and mode inputs with the line, and writes to the ID offset that change nothing.

// File: rtl/dbell_pkg.sv
package dbell_pkg;

    localparam int DATA_W = 32;
    localparam int ADDR_W = 8;
    localparam int PEER_W = 16;
    localparam int VEC_W  = 8;

    typedef enum logic [5:0] {
        WIDX_MASK = 6'd0,
        WIDX_STAT = 6'd1,
        WIDX_ID   = 6'd2,
        WIDX_RING = 6'd3
    } reg_idx_e;

    typedef struct packed {
        logic [PEER_W-1:0] peer;
        logic [VEC_W-1:0]  vec;
    } ring_req_t;

    function automatic ring_req_t unpack_ring(input logic [DATA_W-1:0] w);
        ring_req_t r;
        r.peer = w[31:16];
        r.vec  = w[VEC_W-1:0];
        return r;
    endfunction

endpackage

// File: rtl/dbell_peer_table.sv
module dbell_peer_table #(
    parameter int NUM_PEERS = 16,
    parameter int IDX_W     = $clog2(NUM_PEERS),
    parameter int CNT_W     = 8,
    parameter int PEER_W    = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tbl_we,
    input  logic [IDX_W-1:0]  tbl_idx,
    input  logic [CNT_W-1:0]  tbl_cnt,
    input  logic [PEER_W-1:0] chk_peer,
    input  logic [CNT_W-1:0]  chk_vec,
    output logic              chk_ok
);

    logic [CNT_W-1:0] cnt_q [NUM_PEERS];

    for (genvar g = 0; g < NUM_PEERS; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst)
                cnt_q[g] <= '0;
            else if (tbl_we && (32'(tbl_idx) == g))
                cnt_q[g] <= tbl_cnt;
        end
    end

    logic             peer_in_range;
    logic [CNT_W-1:0] sel_cnt;

    always_comb begin
        peer_in_range = (32'(chk_peer) < NUM_PEERS);
        sel_cnt       = '0;
        if (peer_in_range)
            sel_cnt = cnt_q[chk_peer[IDX_W-1:0]];
        chk_ok = peer_in_range && (chk_vec < sel_cnt);
    end

endmodule

// File: rtl/dbell_irq_ctrl.sv
module dbell_irq_ctrl #(
    parameter int NUM_VEC = 4,
    parameter int DATA_W  = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mask_we,
    input  logic              stat_we,
    input  logic              stat_rd_clr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              msi_mode,
    input  logic              pin_present,
    input  logic              msix_enable,
    input  logic [NUM_VEC-1:0] event_in,
    output logic [DATA_W-1:0] mask_q,
    output logic [DATA_W-1:0] stat_q,
    output logic              irq_level,
    output logic [NUM_VEC-1:0] msg_req
);

    logic line_ev;
    assign line_ev = (|event_in) && !msi_mode;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q  <= '0;
            stat_q  <= '0;
            msg_req <= '0;
        end else begin
            if (mask_we)
                mask_q <= wdata;
            if (line_ev)
                stat_q <= DATA_W'(1);
            else if (stat_we)
                stat_q <= wdata;
            else if (stat_rd_clr)
                stat_q <= '0;
            msg_req <= (msi_mode && msix_enable) ? event_in : '0;
        end
    end

    assign irq_level = !msi_mode && pin_present && ((stat_q & mask_q) != '0);

    assert_mask_load_R2: assert property (@(posedge clk) disable iff (rst)
        mask_we |=> (mask_q == $past(wdata)));

    assert_read_clears_R4: assert property (@(posedge clk) disable iff (rst)
        (stat_rd_clr && !line_ev) |=> (stat_q == '0));

    assert_event_sets_one_R7: assert property (@(posedge clk) disable iff (rst)
        line_ev |=> (stat_q == DATA_W'(1)));

    assert_msg_gated_R8: assert property (@(posedge clk) disable iff (rst)
        (msg_req != '0) |-> $past(msi_mode && msix_enable));

endmodule

// File: rtl/dbell_regs_top.sv
module dbell_regs_top
    import dbell_pkg::*;
#(
    parameter int NUM_PEERS = 16,
    parameter int NUM_VEC   = 4,
    parameter int IDX_W     = $clog2(NUM_PEERS)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               reg_valid,
    input  logic               reg_write,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    input  logic [PEER_W-1:0]  own_id,
    input  logic               msi_mode,
    input  logic               pin_present,
    input  logic               msix_enable,
    input  logic [NUM_VEC-1:0] event_in,
    output logic               irq_level,
    output logic [NUM_VEC-1:0] msg_req,
    output logic               ring_valid,
    output logic [PEER_W-1:0]  ring_peer,
    output logic [VEC_W-1:0]   ring_vec,
    input  logic               tbl_we,
    input  logic [IDX_W-1:0]   tbl_idx,
    input  logic [VEC_W-1:0]   tbl_cnt
);

    reg_idx_e   acc_idx;
    logic       aligned, wr_acc, rd_acc;
    logic       mask_we, stat_we, ring_we, stat_rd_clr;
    ring_req_t  req;
    logic       chk_ok;
    logic [DATA_W-1:0] mask_q, stat_q;

    always_comb begin
        acc_idx     = reg_idx_e'(reg_addr[ADDR_W-1:2]);
        aligned     = (reg_addr[1:0] == 2'b00);
        wr_acc      = reg_valid && reg_write;
        rd_acc      = reg_valid && !reg_write;
        mask_we     = wr_acc && (acc_idx == WIDX_MASK);
        stat_we     = wr_acc && (acc_idx == WIDX_STAT);
        ring_we     = wr_acc && (acc_idx == WIDX_RING);
        stat_rd_clr = rd_acc && aligned && (acc_idx == WIDX_STAT);
        req         = unpack_ring(reg_wdata);
    end

    dbell_peer_table #(
        .NUM_PEERS (NUM_PEERS),
        .IDX_W     (IDX_W),
        .CNT_W     (VEC_W),
        .PEER_W    (PEER_W)
    ) u_table (
        .clk      (clk),
        .rst      (rst),
        .tbl_we   (tbl_we),
        .tbl_idx  (tbl_idx),
        .tbl_cnt  (tbl_cnt),
        .chk_peer (req.peer),
        .chk_vec  (req.vec),
        .chk_ok   (chk_ok)
    );

    dbell_irq_ctrl #(
        .NUM_VEC (NUM_VEC),
        .DATA_W  (DATA_W)
    ) u_irq (
        .clk         (clk),
        .rst         (rst),
        .mask_we     (mask_we),
        .stat_we     (stat_we),
        .stat_rd_clr (stat_rd_clr),
        .wdata       (reg_wdata),
        .msi_mode    (msi_mode),
        .pin_present (pin_present),
        .msix_enable (msix_enable),
        .event_in    (event_in),
        .mask_q      (mask_q),
        .stat_q      (stat_q),
        .irq_level   (irq_level),
        .msg_req     (msg_req)
    );

    logic [DATA_W-1:0] rd_mux;
    always_comb begin
        rd_mux = '0;
        if (aligned) begin
            unique case (acc_idx)
                WIDX_MASK: rd_mux = mask_q;
                WIDX_STAT: rd_mux = stat_q;
                WIDX_ID:   rd_mux = DATA_W'(own_id);
                default:   rd_mux = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            reg_rdata  <= '0;
            ring_valid <= 1'b0;
            ring_peer  <= '0;
            ring_vec   <= '0;
        end else begin
            if (rd_acc)
                reg_rdata <= rd_mux;
            ring_valid <= ring_we && chk_ok;
            if (ring_we && chk_ok) begin
                ring_peer <= req.peer;
                ring_vec  <= req.vec;
            end
        end
    end

    assert_bad_ring_dropped_R6: assert property (@(posedge clk) disable iff (rst)
        (ring_we && !chk_ok) |=> !ring_valid);

    assert_ring_peer_range_R5: assert property (@(posedge clk) disable iff (rst)
        ring_valid |-> (32'(ring_peer) < NUM_PEERS));

endmodule

// File: tb/dbell_regs_top_tb.sv
module dbell_regs_top_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 4;
    localparam int IW = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_valid = 1'b0, reg_write = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [15:0] own_id = 16'h00A5;
    logic        msi_mode = 1'b0, pin_present = 1'b1, msix_enable = 1'b0;
    logic [NV-1:0] event_in = '0;
    logic        irq_level;
    logic [NV-1:0] msg_req;
    logic        ring_valid;
    logic [15:0] ring_peer;
    logic [7:0]  ring_vec;
    logic        tbl_we = 1'b0;
    logic [IW-1:0] tbl_idx = '0;
    logic [7:0]  tbl_cnt = '0;

    int n_chk = 0, n_bad = 0;
    bit done = 0;
    logic        seen_ring;
    logic [15:0] seen_peer;
    logic [7:0]  seen_vec;
    logic [NV-1:0] seen_msg;

    always #(CLK_PERIOD/2) clk = ~clk;

    dbell_regs_top #(.NUM_PEERS(16), .NUM_VEC(NV)) dut_i (
        .clk(clk), .rst(rst), .reg_valid(reg_valid), .reg_write(reg_write),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .own_id(own_id), .msi_mode(msi_mode), .pin_present(pin_present),
        .msix_enable(msix_enable), .event_in(event_in), .irq_level(irq_level),
        .msg_req(msg_req), .ring_valid(ring_valid), .ring_peer(ring_peer),
        .ring_vec(ring_vec), .tbl_we(tbl_we), .tbl_idx(tbl_idx), .tbl_cnt(tbl_cnt)
    );

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", what, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_valid = 1'b1; reg_write = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_valid = 1'b0; reg_write = 1'b0;
        seen_ring = ring_valid; seen_peer = ring_peer; seen_vec = ring_vec;
        @(negedge clk);
    endtask

    task automatic reg_rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_valid = 1'b1; reg_write = 1'b0; reg_addr = a;
        @(negedge clk);
        reg_valid = 1'b0;
        d = reg_rdata;
    endtask

    task automatic tbl_wr(input int idx, input logic [7:0] c);
        @(negedge clk);
        tbl_we = 1'b1; tbl_idx = IW'(idx); tbl_cnt = c;
        @(negedge clk);
        tbl_we = 1'b0;
    endtask

    task automatic pulse_event(input logic [NV-1:0] e);
        @(negedge clk);
        event_in = e;
        @(negedge clk);
        event_in = '0;
        seen_msg = msg_req;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        chk("R1 rdata after reset", reg_rdata, 0);
        chk("R1 irq after reset", 32'(irq_level), 0);
        chk("R1 ring after reset", 32'(ring_valid), 0);
        chk("R1 msg after reset", 32'(msg_req), 0);
        reg_rd(8'h00, d); chk("R1 mask reset", d, 0);
        reg_rd(8'h04, d); chk("R1 status reset", d, 0);
        reg_wr(8'h0C, 32'h0000_0000);
        chk("R1 count zero drops doorbell", 32'(seen_ring), 0);
    endtask

    task automatic t_mask();
        logic [31:0] d;
        reg_wr(8'h01, 32'hFFFF_0001);
        reg_rd(8'h00, d); chk("R2 mask via misaligned write", d, 32'hFFFF_0001);
        reg_wr(8'h00, 32'h0000_0000);
        reg_rd(8'h00, d); chk("R2 mask rewrite", d, 0);
    endtask

    task automatic t_line_irq();
        reg_wr(8'h04, 32'h0000_0002);
        reg_wr(8'h00, 32'h0000_0001);
        chk("R3 irq masked off", 32'(irq_level), 0);
        reg_wr(8'h00, 32'h0000_0003);
        chk("R3 irq on", 32'(irq_level), 1);
    endtask

    task automatic t_stat_read();
        logic [31:0] d;
        reg_rd(8'h04, d); chk("R4 status read value", d, 32'h2);
        chk("R4 irq dropped", 32'(irq_level), 0);
        reg_rd(8'h04, d); chk("R4 status cleared", d, 0);
    endtask

    task automatic t_event_line();
        logic [31:0] d;
        reg_wr(8'h04, 32'h0000_0006);
        pulse_event(4'b0100);
        chk("R7 msg silent in line mode", 32'(seen_msg), 0);
        chk("R7 irq from event", 32'(irq_level), 1);
        reg_rd(8'h04, d); chk("R7 status overwritten to 1", d, 1);
    endtask

    task automatic t_msi();
        logic [31:0] d;
        msi_mode = 1'b1; msix_enable = 1'b1;
        pulse_event(4'b0100);
        chk("R8 msg request vector 2", 32'(seen_msg), 32'h4);
        @(negedge clk);
        chk("R8 msg one cycle", 32'(msg_req), 0);
        reg_rd(8'h04, d); chk("R8 status untouched", d, 0);
        msix_enable = 1'b0;
        pulse_event(4'b0001);
        chk("R8 msg blocked when disabled", 32'(seen_msg), 0);
        reg_wr(8'h04, 32'h1);
        chk("R9 irq low in msg mode", 32'(irq_level), 0);
        msi_mode = 1'b0; pin_present = 1'b0;
        @(negedge clk);
        chk("R9 irq low with pin absent", 32'(irq_level), 0);
        pin_present = 1'b1;
        @(negedge clk);
        chk("R3 irq back with pin present", 32'(irq_level), 1);
        reg_rd(8'h04, d);
    endtask

    task automatic t_doorbell();
        tbl_wr(3, 8'd2);
        tbl_wr(15, 8'd1);
        reg_wr(8'h0C, {16'd3, 8'hFF, 8'd1});
        chk("R5 strobe", 32'(seen_ring), 1);
        chk("R5 peer", 32'(seen_peer), 3);
        chk("R5 vec", 32'(seen_vec), 1);
        chk("R5 strobe single cycle", 32'(ring_valid), 0);
        reg_wr(8'h0C, {16'd3, 8'd0, 8'd2});
        chk("R6 vector at count dropped", 32'(seen_ring), 0);
        reg_wr(8'h0C, {16'd16, 8'd0, 8'd0});
        chk("R6 peer out of range dropped", 32'(seen_ring), 0);
        reg_wr(8'h0C, {16'd15, 8'd0, 8'd0});
        chk("R11 peer 15 count used", 32'(seen_ring), 1);
        chk("R11 peer 15 id", 32'(seen_peer), 15);
        tbl_wr(3, 8'd0);
        reg_wr(8'h0C, {16'd3, 8'd0, 8'd0});
        chk("R11 count rewrite to zero", 32'(seen_ring), 0);
    endtask

    task automatic t_unmapped();
        logic [31:0] d;
        reg_wr(8'h00, 32'h0000_00F0);
        reg_rd(8'h08, d); chk("R10 own id", d, 32'h00A5);
        reg_rd(8'h10, d); chk("R10 unmapped read", d, 0);
        reg_rd(8'h0C, d); chk("R10 doorbell reads zero", d, 0);
        reg_rd(8'h01, d); chk("R10 misaligned read", d, 0);
        reg_wr(8'h08, 32'hDEAD_BEEF);
        chk("R10 id write no strobe", 32'(seen_ring), 0);
        reg_wr(8'h40, 32'hDEAD_BEEF);
        reg_rd(8'h00, d); chk("R10 mask unchanged", d, 32'h0000_00F0);
        reg_rd(8'h04, d); chk("R10 status unchanged", d, 0);
        reg_rd(8'h08, d); chk("R10 id unchanged", d, 32'h00A5);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_mask();
        t_line_irq();
        t_stat_read();
        t_event_line();
        t_msi();
        t_doorbell();
        t_unmapped();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule